// File: doc/BRIEF.md
# Maskable Interrupt Acceptance and Restart Vectoring

This block is the interrupt front end of a small 8-bit processor core. It holds the interrupt-enable flip-flop, which the core sets and clears with one-cycle strobes from its enable-interrupts and disable-interrupts instructions. It also watches a level-sensitive maskable request line. The core marks each instruction with a strobe one clock before the final T-state, which is the sample point, and with a second strobe on the final T-state, which is the end point.

A request seen at the sample point while interrupts are enabled is held as pending. It is accepted only when the current instruction reaches its end point. On acceptance, the block does three things: it clears the enable flip-flop, it outputs the return address (program counter plus instruction length) with a push strobe for the stack, and it raises the acknowledge strobe for one cycle. External logic answers by placing a restart opcode of the form 11nnn111 on the data bus. The block captures that byte at the end of the acknowledge cycle. It then gives either the call address nnn*8 or, for any other byte, an error pulse.

Top module: `irq_front`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, ie_o, inta_o, push_o, vector_valid_o and opcode_err_o are all 0.
- R2: A pulse on ei_i sets ie_o from the next cycle. A pulse on di_i clears it from the next cycle, and di_i wins when both are high.
- R3: When ie_o is 0, a request causes no push_o, inta_o, vector_valid_o or opcode_err_o pulse, and ie_o stays 0.
- R4: intr_i is looked at only in the cycle where sample_i is high. A request that is low there is not accepted, even if intr_i is high at the end point. A request that is high there is accepted even if intr_i has fallen by the end point.
- R5: A pending request is accepted only at the clock edge where instr_end_i is high. No push_o or inta_o appears in the cycle between the sample point and the end point.
- R6: Acceptance clears ie_o. ie_o reads 0 in the cycle where push_o is high.
- R7: In the cycle after the accepting edge, inta_o and push_o are both high for exactly one cycle. In that cycle ret_addr_o equals pc_i + instr_len_i, as sampled at the accepting edge, modulo 2^16.
- R8: data_i is captured at the clock edge that ends the inta_o cycle. If the byte has bits [7:6]=11 and bits [2:0]=111, vector_valid_o pulses in the next cycle with vector_o = {10'b0, data_i[5:3], 3'b000}. For example, 0xEF gives 0x0028.
- R9: A captured byte that does not match 11xxx111 pulses opcode_err_o in the next cycle, and vector_valid_o stays 0.
- R10: A request still high after ie_o is set again is accepted again at the next instruction's end point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| intr_i | input | 1 | Maskable request, level sensitive |
| sample_i | input | 1 | Sample point, one clock before the final T-state |
| instr_end_i | input | 1 | Final T-state of the current instruction |
| pc_i | input | 16 | Address of the current instruction |
| instr_len_i | input | 2 | Length of the current instruction in bytes |
| data_i | input | 8 | Data bus, carries the restart opcode during acknowledge |
| ie_o | output | 1 | Interrupt-enable flip-flop |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| push_o | output | 1 | One-cycle stack push request |
| ret_addr_o | output | 16 | Return address to push |
| vector_valid_o | output | 1 | One-cycle strobe, vector_o is valid |
| vector_o | output | 16 | Restart call address |
| opcode_err_o | output | 1 | One-cycle strobe, captured byte is not a restart |

## Verification
The end-point edge is the reference. push_o, ret_addr_o, inta_o and the cleared ie_o are due in the first cycle after it, and vector_o or opcode_err_o is due in the second cycle. ie_o follows an enable or disable strobe by one cycle. The driver changes inputs on falling edges and queues each expected push, vector or error as it starts an instruction. The monitor samples just after each rising edge and pops the queue whenever an event strobe is high, so an event that comes early, late or unasked for is a mismatch. The instruction task also checks inta_o, push_o and ie_o directly in the cycles before, during and after acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned SHIFT   = 3;

  typedef enum logic {ST_IDLE, ST_ACK} seq_state_e;

  // restart opcode form 11nnn111
  function automatic logic is_restart(input logic [OPC_W-1:0] opc);
    return (opc[7:6] == 2'b11) && (opc[2:0] == 3'b111);
  endfunction

  function automatic logic [FIELD_W-1:0] restart_num(input logic [OPC_W-1:0] opc);
    return opc[5:3];
  endfunction
endpackage

// File: rtl/irq_enable_ff.sv
module irq_enable_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic accept_i,
  output logic ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ie_o <= 1'b0;
    else if (accept_i) ie_o <= 1'b0;
    else if (di_i)     ie_o <= 1'b0;
    else if (ei_i)     ie_o <= 1'b1;
  end
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intr_i,
  input  logic sample_i,
  input  logic instr_end_i,
  input  logic ie_i,
  input  logic idle_i,
  output logic accept_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         pending_q <= 1'b0;
    else if (instr_end_i)                pending_q <= 1'b0;
    else if (sample_i && ie_i && intr_i) pending_q <= 1'b1;
    else if (sample_i)                   pending_q <= 1'b0;
  end

  // a disable between sample and end cancels the pending request
  assign accept_o = instr_end_i && pending_q && ie_i && idle_i;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  instr_len_i,
  output logic              idle_o,
  output logic              inta_o,
  output logic              capture_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] ret_addr_o
);
  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_i) state_d = ST_ACK;
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      push_o     <= 1'b0;
      ret_addr_o <= '0;
    end else begin
      state_q <= state_d;
      push_o  <= accept_i;
      if (accept_i) ret_addr_o <= pc_i + {{PAD_W{1'b0}}, instr_len_i};
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign inta_o    = (state_q == ST_ACK);
  assign capture_o = inta_o;
endmodule

// File: rtl/irq_rst_decode.sv
module irq_rst_decode
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [OPC_W-1:0]  data_i,
  output logic              vector_valid_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              opcode_err_o
);
  localparam int unsigned HI_W = ADDR_W - FIELD_W - SHIFT;

  logic match;
  assign match = is_restart(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_valid_o <= 1'b0;
      opcode_err_o   <= 1'b0;
      vector_o       <= '0;
    end else begin
      vector_valid_o <= capture_i && match;
      opcode_err_o   <= capture_i && !match;
      if (capture_i && match)
        vector_o <= {{HI_W{1'b0}}, restart_num(data_i), {SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              intr_i,
  input  logic              sample_i,
  input  logic              instr_end_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  instr_len_i,
  input  logic [OPC_W-1:0]  data_i,
  output logic              ie_o,
  output logic              inta_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              vector_valid_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              opcode_err_o
);
  logic accept, idle, capture;

  irq_enable_ff i_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ei_i     (ei_i),
    .di_i     (di_i),
    .accept_i (accept),
    .ie_o     (ie_o)
  );

  irq_sampler i_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .intr_i      (intr_i),
    .sample_i    (sample_i),
    .instr_end_i (instr_end_i),
    .ie_i        (ie_o),
    .idle_i      (idle),
    .accept_o    (accept)
  );

  irq_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .pc_i        (pc_i),
    .instr_len_i (instr_len_i),
    .idle_o      (idle),
    .inta_o      (inta_o),
    .capture_o   (capture),
    .push_o      (push_o),
    .ret_addr_o  (ret_addr_o)
  );

  irq_rst_decode #(.ADDR_W(ADDR_W)) i_decode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_i      (capture),
    .data_i         (data_i),
    .vector_valid_o (vector_valid_o),
    .vector_o       (vector_o),
    .opcode_err_o   (opcode_err_o)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ie_o,
  input logic              inta_o,
  input logic              push_o,
  input logic              vector_valid_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic              opcode_err_o
);
  p_no_accept_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(ie_o));
  p_ie_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !ie_o);
  p_push_with_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o == inta_o);
  p_ack_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o);
  p_result_after_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> (vector_valid_o != opcode_err_o));
  p_vector_from_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> $past(inta_o));
  p_vector_form_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> (vector_o[2:0] == 3'b000 && vector_o[ADDR_W-1:6] == '0));
  p_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_err_o |-> (!vector_valid_o && $past(inta_o)));
endmodule

bind irq_front irq_front_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ie_o           (ie_o),
  .inta_o         (inta_o),
  .push_o         (push_o),
  .vector_valid_o (vector_valid_o),
  .vector_o       (vector_o),
  .opcode_err_o   (opcode_err_o)
);

// File: tb/test_irq_front.sv
module test_irq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ei = 0, di = 0, intr = 0, sample = 0, iend = 0;
  logic [15:0] pc = '0;
  logic [1:0]  len = '0;
  logic [7:0]  bus = '0;
  logic        ie_o, inta_o, push_o, vector_valid_o, opcode_err_o;
  logic [15:0] ret_addr_o, vector_o;

  int n_cmp = 0, n_bad = 0;
  bit ie_m = 0;
  string cur_req = "R1";

  typedef struct {int kind; logic [15:0] val; string req;} exp_t; // 0 push,1 vector,2 error
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  irq_front i_irq_front (
    .clk_i(clk), .rst_ni(rst_n), .ei_i(ei), .di_i(di), .intr_i(intr),
    .sample_i(sample), .instr_end_i(iend), .pc_i(pc), .instr_len_i(len),
    .data_i(bus), .ie_o(ie_o), .inta_o(inta_o), .push_o(push_o),
    .ret_addr_o(ret_addr_o), .vector_valid_o(vector_valid_o),
    .vector_o(vector_o), .opcode_err_o(opcode_err_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_evt(input int kind, input logic [15:0] val);
    exp_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s unexpected event actual kind=%0d val=%h expected none", cur_req, kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val !== val) begin
        n_bad++;
        $display("FAIL %s actual kind=%0d val=%h expected kind=%0d val=%h",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (push_o)         check_evt(0, ret_addr_o);
      if (vector_valid_o) check_evt(1, vector_o);
      if (opcode_err_o)   check_evt(2, 16'h0);
    end
  end

  task automatic do_ei();
    @(negedge clk) ei = 1;
    @(negedge clk) ei = 0;
    ie_m = 1;
    check("R2", {15'b0, ie_o}, 16'd1);
  endtask

  task automatic do_di();
    @(negedge clk) di = 1;
    @(negedge clk) di = 0;
    ie_m = 0;
    check("R2", {15'b0, ie_o}, 16'd0);
  endtask

  task automatic run_instr(input string req, input logic [15:0] p, input logic [1:0] l,
                           input bit s, input bit e, input logic [7:0] opc, input bit keep);
    bit acc;
    exp_t x;
    cur_req = req;
    acc = ie_m && s;
    bus = opc;
    if (acc) begin
      x.kind = 0; x.val = p + {14'b0, l}; x.req = req; exp_q.push_back(x);
      if (opc[7:6] == 2'b11 && opc[2:0] == 3'b111) begin
        x.kind = 1; x.val = {10'b0, opc[5:3], 3'b000};
      end else begin
        x.kind = 2; x.val = 16'h0;
      end
      exp_q.push_back(x);
      ie_m = 0;
    end
    @(negedge clk) sample = 1; intr = s;
    @(negedge clk) sample = 0; iend = 1; intr = e; pc = p; len = l;
    check("R5", {14'b0, push_o, inta_o}, 16'd0);
    @(negedge clk) iend = 0; if (!keep) intr = 0;
    check(req, {15'b0, inta_o}, {15'b0, acc});
    check("R6", {15'b0, ie_o}, {15'b0, ie_m});
    @(negedge clk);
    check("R7", {15'b0, inta_o}, 16'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {12'b0, ie_o, inta_o, push_o, vector_valid_o | opcode_err_o}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {12'b0, ie_o, inta_o, push_o, vector_valid_o | opcode_err_o}, 16'd0);

    run_instr("R3", 16'h0100, 2'd1, 1, 1, 8'hEF, 0);
    check("R3", {15'b0, ie_o}, 16'd0);
    do_ei();
    do_di();
    run_instr("R3", 16'h0200, 2'd2, 1, 1, 8'hEF, 0);

    do_ei();
    run_instr("R8", 16'h1234, 2'd3, 1, 1, 8'hEF, 0);

    do_ei();
    run_instr("R4", 16'h0300, 2'd1, 0, 1, 8'hEF, 0);
    check("R4", {15'b0, ie_o}, 16'd1);
    run_instr("R4", 16'h0310, 2'd2, 1, 0, 8'hCF, 0);

    for (int n = 0; n < 8; n++) begin
      do_ei();
      run_instr("R8", 16'h4000 + 16'(n * 16'h0111), 2'(n % 3 + 1), 1, 1,
                {2'b11, 3'(n), 3'b111}, 0);
    end

    do_ei();
    run_instr("R7", 16'hFFFE, 2'd3, 1, 1, 8'hFF, 0);

    do_ei();
    run_instr("R9", 16'h0500, 2'd1, 1, 1, 8'h3E, 0);
    do_ei();
    run_instr("R9", 16'h0600, 2'd1, 1, 1, 8'hC6, 0);
    do_ei();
    run_instr("R9", 16'h0700, 2'd2, 1, 1, 8'h00, 0);

    do_ei();
    run_instr("R10", 16'h0800, 2'd1, 1, 1, 8'hD7, 1);
    run_instr("R10", 16'h0801, 2'd1, 1, 1, 8'hD7, 1);
    do_ei();
    run_instr("R10", 16'h0900, 2'd3, 1, 1, 8'hF7, 0);

    repeat (4) @(negedge clk);
    check("R5", 16'(exp_q.size()), 16'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule